// File: doc/BRIEF.md
# PCI Burst Master Controller

This block is the initiator side of a PCI-style shared parallel bus. A user-side request (command, 64-bit address, beat count, wide flag) is accepted while the block is idle. The block then raises its private request line and waits for a grant while the bus is quiet. Once it has the bus it runs one address phase, or two when the address needs its upper half. It then runs the data phases and closes the transaction with a one-clock turnaround before it releases its drivers.

The target controls the pace through its ready, claim and stop inputs. A target may end a burst early with stop. When stop arrives before the master has entered a data phase, the block goes straight to a single final phase that does not wait for ready. A target that never claims the transaction within the claim window causes a master abort, and the abort is reported to the user side. The 64-bit lane handshake and the dual address cycle are both used only when they are needed.

Top module: `pci_burst_master`

## Requirements
- R1: During and after reset, with no request pending, `req_n`, `frame_n`, `irdy_n` and `req64_n` are high, `ad_oe` and `cbe_oe` are low, and `busy`, `done` and `err` are low.
- R2: `req_n` is low in every clock from the one after a request is accepted until the address phase begins. `frame_n` falls only after an edge at which `gnt_n` was sampled low and both `frame_in_n` and `irdy_in_n` were sampled high.
- R3: When address bits 63:32 are zero, exactly one address phase is driven, with `ad_o[31:0]` equal to address bits 31:0, `ad_o[63:32]` zero and `cbe_o[3:0]` equal to the command.
- R4: When address bits 63:32 are nonzero and the command is not 4'b0000, two address phases are driven. The first carries `cbe_o[3:0]`=4'b1101 with address bits 31:0 on `ad_o[31:0]`. The second carries the command with address bits 63:32 on `ad_o[31:0]`.
- R5: Command 4'b0000 (interrupt acknowledge) always uses one address phase, with `ad_o` all zero, whatever the requested address.
- R6: `cbe_oe` is high in every clock in which `frame_n` or `irdy_n` is low.
- R7: `irdy_n` stays low through the data phases. A phase completes at an edge where `trdy_n` and `devsel_n` are both low, and `beat_ack` is high in that clock. After the requested number of beats (at least 1), `frame_n` is high only during the final phase. For writes (command bit 0 set), `ad_o[31:0]` carries `wr_data[31:0]` in every data phase.
- R8: If `stop_n` is sampled low during an address phase, the first data clock has `frame_n` high and `irdy_n` low. It is the only clock with `irdy_n` low, whatever `trdy_n` does.
- R9: If `stop_n` is sampled low in a data phase while `frame_n` is low, the next phase is the final one (`frame_n` high). That final phase ends at the first edge where ready is complete or stop is low.
- R10: When a wide transfer is requested and the command is not 4'b0000, `req64_n` is low exactly in the clocks where `frame_n` is low. Otherwise `req64_n` stays high. `rd_data[63:32]` equals `ad_i[63:32]` when `ack64_n` is low, and is zero otherwise.
- R11: If `devsel_n` is not sampled low at any of the first 5 edges counted from the end of the first address phase, the master aborts. It drives one clock with `frame_n` high and `irdy_n` low, then the turnaround clock with `err` high.
- R12: After the final phase, exactly one turnaround clock follows, with `frame_n` and `irdy_n` high and `cbe_oe` high (`ad_oe` too for writes). In the next clock both output enables are low.
- R13: `done` is high for exactly the turnaround clock of each transaction. `busy` is high from the clock after acceptance until that turnaround clock ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | User request, accepted while idle |
| req_cmd | input | 4 | Bus command code |
| req_addr | input | 64 | Target byte address |
| req_len | input | 8 | Number of data phases (>=1) |
| req_wide | input | 1 | Ask for a 64-bit transfer |
| wr_data | input | 64 | Write data for the current phase |
| busy | output | 1 | Transaction in progress |
| beat_ack | output | 1 | Current data phase completes at the next edge |
| rd_data | output | 64 | Read data for a completing phase |
| done | output | 1 | Turnaround clock of a finished transaction |
| err | output | 1 | Turnaround clock of a master abort |
| req_n | output | 1 | Private bus request, active low |
| gnt_n | input | 1 | Private bus grant, active low |
| frame_in_n | input | 1 | Observed bus frame, for idle detection |
| irdy_in_n | input | 1 | Observed bus initiator-ready, for idle detection |
| frame_n | output | 1 | Frame driven by this master |
| irdy_n | output | 1 | Initiator ready driven by this master |
| req64_n | output | 1 | 64-bit transfer request |
| ack64_n | input | 1 | 64-bit transfer acknowledge from target |
| trdy_n | input | 1 | Target ready |
| devsel_n | input | 1 | Target claim |
| stop_n | input | 1 | Target stop request |
| ad_i | input | 64 | Address/data lanes as seen on the bus |
| ad_o | output | 64 | Address/data lanes driven by this master |
| ad_oe | output | 1 | Drive enable for `ad_o` |
| cbe_o | output | 8 | Command / byte-enable lanes |
| cbe_oe | output | 1 | Drive enable for `cbe_o` |

## Verification
The bench goes after the two stop timings. A design that waited for ready after an early stop would hold `irdy_n` low until ready came. A design that ignored stop in mid-burst would keep transferring past the requested end. It probes the claim window at both edges, with a claim at the fifth edge and at the sixth. An off-by-one counter would abort a valid transaction or let a dead one hang. It also covers the address decisions: a zero upper address that a careless design would still split into two phases, an interrupt acknowledge that it would send with a dual cycle, and a narrow request on which it would still raise the 64-bit request.

// File: rtl/pbm_pkg.sv
package pbm_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_REQ   = 3'd1,
    S_ADDR  = 3'd2,
    S_ADDR2 = 3'd3,
    S_DATA  = 3'd4,
    S_ABORT = 3'd5,
    S_TURN  = 3'd6
  } pbm_state_e;

  localparam logic [3:0] CMD_INTACK   = 4'b0000;
  localparam logic [3:0] CMD_DUALADDR = 4'b1101;

  // Two address phases are only spent when the upper half is in use.
  function automatic logic needs_dual(input logic [3:0] cmd, input logic [31:0] hi);
    return (cmd != CMD_INTACK) && (hi != 32'h0);
  endfunction

  function automatic logic is_write(input logic [3:0] cmd);
    return cmd[0];
  endfunction

  function automatic logic use_wide(input logic [3:0] cmd, input logic want);
    return want && (cmd != CMD_INTACK);
  endfunction

  function automatic logic [31:0] first_addr_word(input logic [3:0] cmd, input logic [31:0] lo);
    return (cmd == CMD_INTACK) ? 32'h0 : lo;
  endfunction

endpackage

// File: rtl/pbm_claim_timer.sv
module pbm_claim_timer #(
  parameter int TMO_CLKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic devsel_n,
  output logic expired
);
  localparam int CW = $clog2(TMO_CLKS + 1);

  logic [CW-1:0] cnt;
  logic          seen;

  assign expired = run && !seen && devsel_n && (cnt == CW'(TMO_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (start) begin
      cnt  <= '0;
      seen <= 1'b0;
    end else if (run) begin
      if (!devsel_n)  seen <= 1'b1;
      else if (!seen) cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pbm_beat_ctr.sv
module pbm_beat_ctr #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len,
  input  logic             dec,
  output logic             rem_le1,
  output logic             rem_two
);
  logic [LEN_W-1:0] rem;

  assign rem_le1 = (rem <= LEN_W'(1));
  assign rem_two = (rem == LEN_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rem <= '0;
    else if (load) rem <= len;
    else if (dec)  rem <= rem - 1'b1;
  end
endmodule

// File: rtl/pci_burst_master.sv
module pci_burst_master
  import pbm_pkg::*;
#(
  parameter int TMO_CLKS = 5,
  parameter int LEN_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [3:0]       req_cmd,
  input  logic [63:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             req_wide,
  input  logic [63:0]      wr_data,
  output logic             busy,
  output logic             beat_ack,
  output logic [63:0]      rd_data,
  output logic             done,
  output logic             err,
  output logic             req_n,
  input  logic             gnt_n,
  input  logic             frame_in_n,
  input  logic             irdy_in_n,
  output logic             frame_n,
  output logic             irdy_n,
  output logic             req64_n,
  input  logic             ack64_n,
  input  logic             trdy_n,
  input  logic             devsel_n,
  input  logic             stop_n,
  input  logic [63:0]      ad_i,
  output logic [63:0]      ad_o,
  output logic             ad_oe,
  output logic [7:0]       cbe_o,
  output logic             cbe_oe
);

  pbm_state_e  st, st_d;
  logic [3:0]  cmd_q;
  logic [63:0] addr_q;
  logic        wide_q, dual_q, write_q;
  logic        early_q, last_q, abort_q;

  // Named internal events
  logic accept, granted, xfer, expired, rem_le1, rem_two, beat_dec, timer_run, frame_on;

  assign accept    = (st == S_IDLE) && req_valid;
  assign granted   = (st == S_REQ) && !gnt_n && frame_in_n && irdy_in_n;
  assign xfer      = !trdy_n && !devsel_n;
  assign beat_dec  = (st == S_DATA) && !last_q && xfer;
  assign timer_run = (st == S_ADDR) || (st == S_ADDR2) || (st == S_DATA);

  pbm_claim_timer #(.TMO_CLKS(TMO_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(granted), .run(timer_run),
    .devsel_n(devsel_n), .expired(expired)
  );

  pbm_beat_ctr #(.LEN_W(LEN_W)) u_beats (
    .clk(clk), .rst_n(rst_n), .load(accept), .len(req_len), .dec(beat_dec),
    .rem_le1(rem_le1), .rem_two(rem_two)
  );

  always_comb begin
    st_d = st;
    case (st)
      S_IDLE:  if (req_valid) st_d = S_REQ;
      S_REQ:   if (granted) st_d = S_ADDR;
      S_ADDR:  if (expired) st_d = S_ABORT;
               else st_d = dual_q ? S_ADDR2 : S_DATA;
      S_ADDR2: st_d = expired ? S_ABORT : S_DATA;
      S_DATA: begin
        if (early_q)      st_d = S_TURN;
        else if (expired) st_d = S_ABORT;
        else if (last_q && (xfer || !stop_n)) st_d = S_TURN;
      end
      S_ABORT: st_d = S_TURN;
      S_TURN:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cmd_q   <= '0;
      addr_q  <= '0;
      wide_q  <= 1'b0;
      dual_q  <= 1'b0;
      write_q <= 1'b0;
      early_q <= 1'b0;
      last_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      st <= st_d;
      if (accept) begin
        cmd_q   <= req_cmd;
        addr_q  <= req_addr;
        wide_q  <= use_wide(req_cmd, req_wide);
        dual_q  <= needs_dual(req_cmd, req_addr[63:32]);
        write_q <= is_write(req_cmd);
      end
      if (granted) begin
        early_q <= 1'b0;
        last_q  <= rem_le1;
        abort_q <= 1'b0;
      end
      if ((st == S_ADDR || st == S_ADDR2) && !stop_n) begin
        early_q <= 1'b1;
        last_q  <= 1'b1;
      end
      if (st == S_DATA && !last_q && (!stop_n || (xfer && rem_two)))
        last_q <= 1'b1;
      if (st == S_ABORT) abort_q <= 1'b1;
    end
  end

  // Bus-side outputs decoded from the registered state
  assign frame_on = (st == S_ADDR) || (st == S_ADDR2) || (st == S_DATA && !last_q);
  assign frame_n  = !frame_on;
  assign irdy_n   = !((st == S_DATA) || (st == S_ABORT));
  assign req64_n  = !(wide_q && frame_on);
  assign req_n    = (st != S_REQ);
  assign cbe_oe   = (st == S_ADDR) || (st == S_ADDR2) || (st == S_DATA) ||
                    (st == S_ABORT) || (st == S_TURN);
  assign ad_oe    = (st == S_ADDR) || (st == S_ADDR2) ||
                    (write_q && ((st == S_DATA) || (st == S_ABORT) || (st == S_TURN)));

  always_comb begin
    ad_o  = '0;
    cbe_o = '0;
    case (st)
      S_ADDR: begin
        ad_o[31:0] = first_addr_word(cmd_q, addr_q[31:0]);
        cbe_o[3:0] = dual_q ? CMD_DUALADDR : cmd_q;
      end
      S_ADDR2: begin
        ad_o[31:0] = addr_q[63:32];
        cbe_o[3:0] = cmd_q;
      end
      S_DATA, S_ABORT, S_TURN: begin
        if (write_q) ad_o = {wide_q ? wr_data[63:32] : 32'h0, wr_data[31:0]};
      end
      default: ;
    endcase
  end

  // User-side outputs
  assign busy     = (st != S_IDLE);
  assign beat_ack = (st == S_DATA) && xfer;
  assign rd_data  = {ack64_n ? 32'h0 : ad_i[63:32], ad_i[31:0]};
  assign done     = (st == S_TURN);
  assign err      = (st == S_TURN) && abort_q;

  // Assertions
  p_start_on_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(frame_n) |-> $past(!gnt_n && frame_in_n && irdy_in_n));

  p_dual_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR2) |-> ($past(st) == S_ADDR && $past(cbe_o[3:0]) == CMD_DUALADDR));

  p_cbe_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_n || !irdy_n) |-> cbe_oe);

  p_early_no_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && early_q) |=> (st == S_TURN && irdy_n));

  p_req64_in_frame_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !req64_n |-> !frame_n);

  p_abort_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ABORT) |=> (err && frame_n && irdy_n));

  p_turn_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TURN) |=> (!cbe_oe && !ad_oe));

  p_done_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/pci_burst_master_tb.sv
module pci_burst_master_tb;
  localparam int TMO = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_cmd = '0;
  logic [63:0] req_addr = '0;
  logic [7:0]  req_len = 8'd1;
  logic        req_wide = 1'b0;
  logic [63:0] wr_data = 64'hCAFE_0001_BEEF_0002;
  logic        busy, beat_ack, done, err, req_n, frame_n, irdy_n, req64_n, ad_oe, cbe_oe;
  logic [63:0] rd_data, ad_o;
  logic [7:0]  cbe_o;
  logic        gnt_n = 1'b1, frame_in_n = 1'b1, irdy_in_n = 1'b1;
  logic        ack64_n = 1'b1, trdy_n = 1'b1, devsel_n = 1'b1, stop_n = 1'b1;
  logic [63:0] ad_i = '0;

  always #2 clk = ~clk;

  pci_burst_master u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_addr(req_addr), .req_len(req_len), .req_wide(req_wide), .wr_data(wr_data),
    .busy(busy), .beat_ack(beat_ack), .rd_data(rd_data), .done(done), .err(err),
    .req_n(req_n), .gnt_n(gnt_n), .frame_in_n(frame_in_n), .irdy_in_n(irdy_in_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .req64_n(req64_n), .ack64_n(ack64_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n), .ad_i(ad_i),
    .ad_o(ad_o), .ad_oe(ad_oe), .cbe_o(cbe_o), .cbe_oe(cbe_oe)
  );

  int n_chk = 0, n_err = 0, cyc = 0;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Target / arbiter configuration
  int  cfg_lat = 1, cfg_div = 1, cfg_stop = 1000;
  bit  cfg_ack64 = 0, cfg_gnt = 1, cfg_other = 0;
  int  idx = 0;
  bit  was_act = 0;

  // Per-transaction observations
  int  t_beats = 0, t_irdy = 0, t_overlap = 0, t_frame = 0, t_r64 = 0, t_err = 0;
  bit  seen_done = 0;

  // Behavioural reference: phase 0 idle,1 request,2 addr,3 addr2,4 data,5 abort,6 turn
  int  m_ph = 0, m_rem = 0, m_cnt = 0;
  bit  m_last = 0, m_early = 0, m_seen = 0, m_abort = 0, m_wide = 0, m_dual = 0, m_wr = 0;
  logic [3:0]  m_cmd = '0;
  logic [63:0] m_addr = '0;

  always @(posedge clk) begin
    bit exp_t, xf;
    cyc++;
    if (!rst_n) begin
      m_ph = 0;
    end else begin
      exp_t = 0;
      if (m_ph >= 2 && m_ph <= 4) begin
        exp_t = !m_seen && devsel_n && (m_cnt == TMO - 1);
        if (!devsel_n) m_seen = 1; else if (!m_seen) m_cnt++;
      end
      xf = !trdy_n && !devsel_n;
      case (m_ph)
        0: if (req_valid) begin
             m_cmd = req_cmd; m_addr = req_addr; m_rem = int'(req_len);
             m_wide = req_wide && (req_cmd != 4'b0000);
             m_dual = (req_cmd != 4'b0000) && (req_addr[63:32] != 0);
             m_wr = req_cmd[0]; m_ph = 1;
           end
        1: if (!gnt_n && frame_in_n && irdy_in_n) begin
             m_ph = 2; m_cnt = 0; m_seen = 0; m_early = 0; m_abort = 0;
             m_last = (m_rem <= 1);
           end
        2, 3: begin
             if (!stop_n) begin m_early = 1; m_last = 1; end
             if (exp_t) m_ph = 5;
             else if (m_ph == 2 && m_dual) m_ph = 3;
             else m_ph = 4;
           end
        4: begin
             if (m_early) m_ph = 6;
             else if (exp_t) m_ph = 5;
             else if (m_last) begin
               if (xf || !stop_n) m_ph = 6;
             end else begin
               if (xf) m_rem--;
               if (!stop_n || (xf && m_rem == 1)) m_last = 1;
             end
           end
        5: begin m_abort = 1; m_ph = 6; end
        default: m_ph = 0;
      endcase
    end
  end

  // Responder drives at the falling edge; comparison 1 ns later
  always @(negedge clk) begin
    bit act, e_fr, e_ir;
    act = !frame_n || !irdy_n;
    if (act) begin
      if (!was_act) idx = 0; else idx++;
    end
    was_act = act;
    devsel_n   = !(act && idx >= cfg_lat);
    trdy_n     = !(act && idx >= cfg_lat && idx >= 1 && (idx % cfg_div) == 0);
    stop_n     = !(act && idx >= cfg_stop);
    ack64_n    = !(act && cfg_ack64 && idx >= cfg_lat);
    gnt_n      = !(!req_n && cfg_gnt);
    frame_in_n = frame_n && !cfg_other;
    irdy_in_n  = irdy_n && !cfg_other;
    ad_i       = {32'hA5A5_0000 + 32'(idx), 32'h1234_0000 + 32'(idx)};
    #1;
    if (rst_n) begin
      e_fr = !(m_ph == 2 || m_ph == 3 || (m_ph == 4 && !m_last));
      e_ir = !(m_ph == 4 || m_ph == 5);
      check("R2 req_n", req_n, m_ph != 1);
      check("R7 frame_n", frame_n, e_fr);
      check("R7 irdy_n", irdy_n, e_ir);
      check("R10 req64_n", req64_n, !(m_wide && !e_fr));
      check("R6 cbe_oe", cbe_oe, m_ph >= 2);
      check("R12 ad_oe", ad_oe, (m_ph == 2 || m_ph == 3) || (m_wr && m_ph >= 4));
      check("R13 done", done, m_ph == 6);
      check("R13 busy", busy, m_ph != 0);
      check("R11 err", err, m_ph == 6 && m_abort);
      check("R7 beat_ack", beat_ack, m_ph == 4 && !trdy_n && !devsel_n);
      if (m_ph == 2) begin
        check("R3 addr lanes", ad_o, {32'h0, (m_cmd == 4'b0000) ? 32'h0 : m_addr[31:0]});
        check("R4 addr cbe", cbe_o[3:0], m_dual ? 4'b1101 : m_cmd);
      end
      if (m_ph == 3) begin
        check("R4 high addr", ad_o[31:0], m_addr[63:32]);
        check("R4 cmd cbe", cbe_o[3:0], m_cmd);
      end
      if (m_ph == 4 && m_wr) check("R7 write data", ad_o[31:0], wr_data[31:0]);
      if (beat_ack && !m_wr)
        check("R10 rd_data", rd_data, {ack64_n ? 32'h0 : ad_i[63:32], ad_i[31:0]});
      if (beat_ack) t_beats++;
      if (!irdy_n) t_irdy++;
      if (!irdy_n && !frame_n) t_overlap++;
      if (!frame_n) t_frame++;
      if (!req64_n) t_r64++;
      if (err) t_err++;
      if (done) seen_done = 1;
    end
  end

  task automatic start_txn(input logic [3:0] c, input logic [63:0] a, input int l, input bit w,
                           input int lat, input int div, input int stp, input bit a64);
    @(negedge clk);
    cfg_lat = lat; cfg_div = div; cfg_stop = stp; cfg_ack64 = a64;
    req_cmd = c; req_addr = a; req_len = 8'(l); req_wide = w; req_valid = 1'b1;
    t_beats = 0; t_irdy = 0; t_overlap = 0; t_frame = 0; t_r64 = 0; t_err = 0; seen_done = 0;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_txn();
    for (int i = 0; i < 300 && !seen_done; i++) @(negedge clk);
    check("R13 completion", seen_done, 1'b1);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_txn(input logic [3:0] c, input logic [63:0] a, input int l, input bit w,
                         input int lat, input int div, input int stp, input bit a64);
    start_txn(c, a, l, w, lat, div, stp, a64);
    finish_txn();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 req_n", req_n, 1'b1);
    check("R1 frame_n", frame_n, 1'b1);
    check("R1 irdy_n", irdy_n, 1'b1);
    check("R1 req64_n", req64_n, 1'b1);
    check("R1 oe", {ad_oe, cbe_oe, busy, done, err}, 5'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: no grant, then grant with a busy bus, then free bus
    cfg_gnt = 0;
    start_txn(4'b0111, 64'h0000_0000_0000_1000, 1, 0, 1, 1, 1000, 0);
    repeat (3) @(negedge clk);
    #1;
    check("R2 waiting req_n", req_n, 1'b0);
    check("R2 waiting frame_n", frame_n, 1'b1);
    cfg_gnt = 1; cfg_other = 1;
    repeat (3) @(negedge clk);
    #1;
    check("R2 busy bus frame_n", frame_n, 1'b1);
    cfg_other = 0;
    finish_txn();
    check("R3 single beat", t_beats, 1);

    // R7 burst read with waits, R10 wide with ack
    run_txn(4'b0110, 64'h0000_0000_0000_2000, 4, 1, 1, 2, 1000, 1);
    check("R7 burst beats", t_beats, 4);
    check("R10 req64 tracks frame", t_r64, t_frame);
    // R10 wide asked without ack: upper read data zero (per-cycle check)
    run_txn(4'b0110, 64'h0000_0000_0000_2100, 3, 1, 2, 1, 1000, 0);
    check("R7 burst beats narrow ack", t_beats, 3);

    // R4 dual address write burst
    run_txn(4'b0111, 64'h0000_0012_0000_3000, 2, 0, 1, 1, 1000, 0);
    check("R4 dual beats", t_beats, 2);
    check("R10 no req64 narrow", t_r64, 0);

    // R5 interrupt acknowledge with a nonzero upper address, wide request
    run_txn(4'b0000, 64'hFFFF_0000_ABCD_0000, 1, 1, 1, 1, 1000, 1);
    check("R5 iack beats", t_beats, 1);
    check("R5 iack no req64", t_r64, 0);

    // R8 early stop, target never ready
    run_txn(4'b0110, 64'h0000_0000_0000_4000, 6, 0, 1, 100, 0, 0);
    check("R8 one irdy clock", t_irdy, 1);
    check("R8 no frame overlap", t_overlap, 0);
    check("R8 no beats", t_beats, 0);
    // R8 early stop during second address phase
    run_txn(4'b0111, 64'h0000_0001_0000_4100, 6, 0, 1, 100, 1, 0);
    check("R8 dual one irdy clock", t_irdy, 1);

    // R9 stop in mid-burst
    run_txn(4'b0111, 64'h0000_0000_0000_5000, 8, 1, 1, 1, 2, 1);
    check("R9 beats after stop", t_beats, 3);
    check("R9 irdy clocks", t_irdy, 3);

    // R11 claim window boundaries
    run_txn(4'b0110, 64'h0000_0000_0000_6000, 1, 0, 4, 1, 1000, 0);
    check("R11 late claim accepted", t_err, 0);
    check("R11 late claim beat", t_beats, 1);
    run_txn(4'b0110, 64'h0000_0000_0000_6100, 2, 0, 5, 1, 1000, 0);
    check("R11 abort at window end", t_err, 1);
    run_txn(4'b0111, 64'h0000_0000_0000_6200, 3, 1, 99, 1, 1000, 0);
    check("R11 abort no claim", t_err, 1);
    check("R11 abort no beats", t_beats, 0);

    // R12 back-to-back after abort
    run_txn(4'b0111, 64'h0000_0000_0000_7000, 2, 0, 1, 1, 1000, 0);
    check("R12 recovery beats", t_beats, 2);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule